// File: doc/BRIEF.md
# Dual-Core Shared Memory Arbiter

This block sits between two 8-bit controller cores and one single-ported memory. The memory holds a 64 KB code region and a 16 MB data region. In each cycle the block grants the memory to one core at most and drives that core's address, strobes and write data onto the memory port. A core that is not granted sees its ready line low and waits until it is granted. When both cores request in the same cycle, the winner is picked round-robin. A core can raise a lock line so that its grant carries over into its next access, up to a fixed number of accesses. In a parameter-selected slotted variant, the grant alternates between the cores on every clock. That variant suits a memory that runs at twice the core rate.

The primary core owns the lower half of code memory and the secondary core owns the upper half. The secondary core is held in reset after power-up. The primary core releases it by writing a control register that sits at a fixed data address. The same register also turns on relocation of the secondary core's code fetches by half the code size. With relocation on, the secondary core's reset and interrupt vectors at address zero land in the upper half of code memory. The boot code can therefore copy both images with flat addressing first and switch relocation on afterwards.

Top module: `dsa_shared_mem`

## Requirements
- R1: In every cycle at most one of `a_ready` and `b_ready` is high, and `mem_en` is high only in a cycle where one of them is high.
- R2: After reset `b_rst_n` is low, and while it stays low a request from the secondary core is never granted (`b_ready` stays 0).
- R3: A data-space access to address `CTRL_ADDR` (default 24'hFFFFFF) never reaches memory (`mem_en` 0). A primary-core write there loads bit 0 into `b_rst_n` (1 = release) and bit 1 into the relocation enable. A read there returns {zeros, relocation enable, release}.
- R4: A secondary-core write to `CTRL_ADDR` changes neither the release bit nor the relocation bit.
- R5: With relocation on, a secondary-core code access drives `mem_addr` bits 15:0 to (address + 0x8000) modulo 0x10000, with all higher bits zero. With relocation off, bits 15:0 pass through unchanged.
- R6: Primary-core code accesses are never relocated and drive only bits 15:0. Data accesses of either core pass all 24 address bits unchanged.
- R7: When both cores request and no lock is active, the grant goes to the core that did not win the most recent granted access. After reset the primary core is favoured.
- R8: A request from a single core with no lock active is granted in the same cycle, and the access completes at the next clock edge.
- R9: An access granted with its lock high keeps the grant for the same core's next access, even across cycles in which that core is idle. At most 4 consecutive accesses are held this way. After that, the other core is granted if it is waiting.
- R10: A granted read loads that core's read-data register at the end of its cycle. The other core's read data and the read data after writes keep their previous values.
- R11: With `PHASED` set, the grant alternates between the cores on every clock, whatever the contention.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_req | input | 1 | Primary core access request |
| a_we | input | 1 | Primary core write (1) or read (0) |
| a_dsp | input | 1 | Primary core space: 1 data, 0 code |
| a_addr | input | 24 | Primary core address |
| a_wdata | input | 8 | Primary core write data |
| a_lock | input | 1 | Primary core keep-grant request |
| a_rdata | output | 8 | Primary core registered read data |
| a_ready | output | 1 | Primary core grant; low means wait |
| b_req | input | 1 | Secondary core access request |
| b_we | input | 1 | Secondary core write (1) or read (0) |
| b_dsp | input | 1 | Secondary core space: 1 data, 0 code |
| b_addr | input | 24 | Secondary core address |
| b_wdata | input | 8 | Secondary core write data |
| b_lock | input | 1 | Secondary core keep-grant request |
| b_rdata | output | 8 | Secondary core registered read data |
| b_ready | output | 1 | Secondary core grant; low means wait |
| b_rst_n | output | 1 | Active-low reset to the secondary core |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write strobe |
| mem_dsp | output | 1 | Memory space select: 1 data, 0 code |
| mem_addr | output | 24 | Memory address after mapping |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid in the access cycle |

## Verification
Contention and locking can both act in the same cycle. A locked run by the primary core meets a waiting secondary request, and the bench holds both request lines high through consecutive cycles while it steps the lock line. Each cycle is judged by the winner that the round-robin rule and the four-access hold bound predict, including a cycle where the lock holder is idle and the waiting core must still get nothing. A second case arises when a control-register write and a relocated code fetch fall in neighbouring cycles. The bench checks that the fetch address follows the new relocation bit and that the register access never reaches memory.

// File: rtl/dsa_pkg.sv
// Package: shared identifiers for the dual-core shared memory arbiter.
// Assumes: exactly two requesters, indexed by core_e.
package dsa_pkg;
    typedef enum logic {
        CORE_PRI = 1'b0,
        CORE_SEC = 1'b1
    } core_e;

    // Control register field positions.
    localparam int CTL_RELEASE_BIT = 0;
    localparam int CTL_RELOC_BIT   = 1;
endpackage

// File: rtl/dsa_arbiter.sv
// Module: grant selection between the two cores.
// Does: picks at most one core per cycle. The default variant is round-robin
//   with a bounded lock hold; the PHASED variant alternates fixed slots.
// Assumes: req is already masked for a core held in reset; gnt is combinational
//   and an access completes at the clock edge that ends a granted cycle.
module dsa_arbiter #(
    parameter int LOCK_MAX = 4,
    parameter bit PHASED   = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] req,
    input  logic [1:0] lock,
    output logic [1:0] gnt
);
    import dsa_pkg::*;

    localparam int CNT_W = $clog2(LOCK_MAX + 1);

    generate
        if (PHASED) begin : g_slot
            logic slot_q;
            logic unused_lock;
            assign unused_lock = ^lock;

            // Slot owner toggles every clock; primary owns the first slot.
            always_ff @(posedge clk) begin
                if (!rst_n) slot_q <= CORE_PRI;
                else        slot_q <= ~slot_q;
            end

            // Only the slot owner may be granted.
            always_comb begin
                gnt         = 2'b00;
                gnt[slot_q] = req[slot_q];
            end
        end else begin : g_rr
            logic             prio_q;
            logic             hold_q;
            logic             holder_q;
            logic [CNT_W-1:0] cnt_q;
            logic             winner;
            logic [CNT_W-1:0] run_n;

            // Grant: lock holder first, then round-robin on contention.
            always_comb begin
                gnt = 2'b00;
                if (hold_q)                gnt[holder_q] = req[holder_q];
                else if (req[0] && req[1]) gnt[prio_q]   = 1'b1;
                else                       gnt           = req;
            end

            assign winner = gnt[1];
            assign run_n  = (hold_q && (holder_q == winner)) ? cnt_q + 1'b1
                                                             : CNT_W'(1);

            // Track turn order and the length of the current locked run.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    prio_q   <= CORE_PRI;
                    hold_q   <= 1'b0;
                    holder_q <= CORE_PRI;
                    cnt_q    <= '0;
                end else if (|gnt) begin
                    prio_q <= ~winner;
                    if (lock[winner] && (run_n < CNT_W'(LOCK_MAX))) begin
                        hold_q   <= 1'b1;
                        holder_q <= winner;
                        cnt_q    <= run_n;
                    end else begin
                        hold_q <= 1'b0;
                        cnt_q  <= '0;
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/dsa_addr_map.sv
// Module: per-core address mapping onto the shared memory.
// Does: data addresses pass unchanged. Code addresses are cut to CODE_W bits
//   and, for the relocating variant with reloc_en high, offset by half the
//   code space (wrapping inside it).
// Assumes: is_data selects the data space.
module dsa_addr_map #(
    parameter int ADDR_W   = 24,
    parameter int CODE_W   = 16,
    parameter bit RELOCATE = 1'b0
) (
    input  logic              is_data,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              reloc_en,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [CODE_W-1:0] HALF = CODE_W'(1) << (CODE_W - 1);

    generate
        if (RELOCATE) begin : g_rel
            logic [CODE_W-1:0] code_a;

            // Offset the code address when relocation is on.
            always_comb begin
                code_a = addr_i[CODE_W-1:0];
                if (reloc_en) code_a = code_a + HALF;
                addr_o = is_data ? addr_i : ADDR_W'(code_a);
            end
        end else begin : g_flat
            logic unused_reloc;
            assign unused_reloc = reloc_en;
            assign addr_o = is_data ? addr_i : ADDR_W'(addr_i[CODE_W-1:0]);
        end
    endgenerate
endmodule

// File: rtl/dsa_ctrl.sv
// Module: secondary-core control register.
// Does: holds the release and relocation bits, loaded only by primary writes.
// Assumes: wr_pri is already qualified by grant, write and address match.
module dsa_ctrl #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_pri,
    input  logic [1:0]        wbits,
    output logic              release_o,
    output logic              reloc_o,
    output logic [DATA_W-1:0] rd_o
);
    import dsa_pkg::*;

    // Load both control bits on a qualified primary write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            release_o <= 1'b0;
            reloc_o   <= 1'b0;
        end else if (wr_pri) begin
            release_o <= wbits[CTL_RELEASE_BIT];
            reloc_o   <= wbits[CTL_RELOC_BIT];
        end
    end

    assign rd_o = DATA_W'({reloc_o, release_o});
endmodule

// File: rtl/dsa_shared_mem.sv
// Module: top of the dual-core shared memory arbiter.
// Does: maps each core's address, grants one core per cycle, multiplexes the
//   granted core onto the memory port, intercepts the control address and
//   registers read data per core.
// Assumes: memory read data is valid combinationally in the access cycle.
module dsa_shared_mem #(
    parameter int                ADDR_W    = 24,
    parameter int                DATA_W    = 8,
    parameter int                CODE_W    = 16,
    parameter int                LOCK_MAX  = 4,
    parameter bit                PHASED    = 1'b0,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_req,
    input  logic              a_we,
    input  logic              a_dsp,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic              a_lock,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_ready,
    input  logic              b_req,
    input  logic              b_we,
    input  logic              b_dsp,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    input  logic              b_lock,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_ready,
    output logic              b_rst_n,
    output logic              mem_en,
    output logic              mem_we,
    output logic              mem_dsp,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    import dsa_pkg::*;

    localparam int NCORE = 2;

    logic [NCORE-1:0]  req_v, we_v, dsp_v, lock_v, gnt, hit_v;
    logic [ADDR_W-1:0] addr_v  [NCORE];
    logic [ADDR_W-1:0] maddr_v [NCORE];
    logic [DATA_W-1:0] wdata_v [NCORE];
    logic              sec_run, reloc_en, sel;
    logic [DATA_W-1:0] ctrl_rd;

    assign req_v      = {b_req & sec_run, a_req};
    assign we_v       = {b_we, a_we};
    assign dsp_v      = {b_dsp, a_dsp};
    assign lock_v     = {b_lock, a_lock};
    assign addr_v[0]  = a_addr;
    assign addr_v[1]  = b_addr;
    assign wdata_v[0] = a_wdata;
    assign wdata_v[1] = b_wdata;

    dsa_arbiter #(
        .LOCK_MAX (LOCK_MAX),
        .PHASED   (PHASED)
    ) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req_v),
        .lock  (lock_v),
        .gnt   (gnt)
    );

    dsa_ctrl #(
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_pri    (gnt[CORE_PRI] && we_v[CORE_PRI] && hit_v[CORE_PRI]),
        .wbits     (wdata_v[CORE_PRI][1:0]),
        .release_o (sec_run),
        .reloc_o   (reloc_en),
        .rd_o      (ctrl_rd)
    );

    generate
        for (genvar i = 0; i < NCORE; i++) begin : g_port
            logic [DATA_W-1:0] rd_q;

            dsa_addr_map #(
                .ADDR_W   (ADDR_W),
                .CODE_W   (CODE_W),
                .RELOCATE (i == int'(CORE_SEC))
            ) u_map (
                .is_data  (dsp_v[i]),
                .addr_i   (addr_v[i]),
                .reloc_en (reloc_en),
                .addr_o   (maddr_v[i])
            );

            assign hit_v[i] = dsp_v[i] && (addr_v[i] == CTRL_ADDR);

            // Capture read data only for this core's granted reads.
            always_ff @(posedge clk) begin
                if (!rst_n)                  rd_q <= '0;
                else if (gnt[i] && !we_v[i]) rd_q <= hit_v[i] ? ctrl_rd : mem_rdata;
            end
        end
    endgenerate

    // Memory port multiplexer steered by the granted core.
    assign sel       = gnt[CORE_SEC];
    assign mem_en    = (|gnt) && !hit_v[sel];
    assign mem_we    = mem_en && we_v[sel];
    assign mem_dsp   = dsp_v[sel];
    assign mem_addr  = maddr_v[sel];
    assign mem_wdata = wdata_v[sel];

    assign a_ready = gnt[CORE_PRI];
    assign b_ready = gnt[CORE_SEC];
    assign a_rdata = g_port[0].rd_q;
    assign b_rdata = g_port[1].rd_q;
    assign b_rst_n = sec_run;
endmodule

// File: rtl/dsa_chk.sv
// Module: property checker for dsa_shared_mem, attached by bind.
// Does: watches the grant, reset-release and read-data behaviour at the ports.
// Assumes: synchronous active-low reset.
module dsa_chk #(
    parameter int DATA_W   = 8,
    parameter int LOCK_MAX = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              a_req,
    input logic              a_we,
    input logic              a_lock,
    input logic              a_ready,
    input logic [DATA_W-1:0] a_rdata,
    input logic              b_req,
    input logic              b_ready,
    input logic [DATA_W-1:0] b_rdata,
    input logic              b_rst_n,
    input logic              mem_en
);
    logic [7:0] streak_q;

    // Count primary grants while the secondary waits, to bound lock runs.
    always_ff @(posedge clk) begin
        if (!rst_n)                            streak_q <= '0;
        else if (b_ready || !(b_req && b_rst_n)) streak_q <= '0;
        else if (a_ready)                      streak_q <= streak_q + 8'd1;
    end

    // R1
    excl_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_ready && b_ready));

    // R1
    mem_en_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> (a_ready || b_ready));

    // R2
    sec_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !b_rst_n |-> !b_ready);

    // R3
    release_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(b_rst_n) |-> $past(a_req && a_ready && a_we));

    // R10
    rdata_hold_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_req && a_ready) |=> $stable(a_rdata));

    // R10
    rdata_hold_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(b_req && b_ready) |=> $stable(b_rdata));

    // R7
    rr_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_req && a_ready && !a_lock) |=> (!(a_req && b_req && b_rst_n) || b_ready));

    // R9
    lock_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(streak_q) <= LOCK_MAX);
endmodule

bind dsa_shared_mem dsa_chk #(
    .DATA_W   (DATA_W),
    .LOCK_MAX (LOCK_MAX)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_req   (a_req),
    .a_we    (a_we),
    .a_lock  (a_lock),
    .a_ready (a_ready),
    .a_rdata (a_rdata),
    .b_req   (b_req),
    .b_ready (b_ready),
    .b_rdata (b_rdata),
    .b_rst_n (b_rst_n),
    .mem_en  (mem_en)
);

// File: tb/sim_dsa_shared_mem.sv
module sim_dsa_shared_mem;
    localparam logic [23:0] CTRL = 24'hFFFFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_req = 0, a_we = 0, a_dsp = 0, a_lock = 0;
    logic [23:0] a_addr = '0;
    logic [7:0]  a_wdata = '0;
    logic        b_req = 0, b_we = 0, b_dsp = 0, b_lock = 0;
    logic [23:0] b_addr = '0;
    logic [7:0]  b_wdata = '0;
    logic [7:0]  a_rdata, b_rdata;
    logic        a_ready, b_ready, b_rst_n;
    logic        mem_en, mem_we, mem_dsp;
    logic [23:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic [7:0]  p_a_rdata, p_b_rdata;
    logic        p_a_ready, p_b_ready, p_b_rst_n;
    logic        p_mem_en, p_mem_we, p_mem_dsp;
    logic [23:0] p_mem_addr;
    logic [7:0]  p_mem_wdata;

    logic [7:0] mem [0:1023];
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    // Sparse memory model: space, bit 15 and low byte form the index.
    assign mem_rdata = mem[{mem_dsp, mem_addr[15], mem_addr[7:0]}];
    always @(posedge clk)
        if (mem_en && mem_we) mem[{mem_dsp, mem_addr[15], mem_addr[7:0]}] <= mem_wdata;

    dsa_shared_mem u0 (
        .clk(clk), .rst_n(rst_n),
        .a_req(a_req), .a_we(a_we), .a_dsp(a_dsp), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_lock(a_lock), .a_rdata(a_rdata), .a_ready(a_ready),
        .b_req(b_req), .b_we(b_we), .b_dsp(b_dsp), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_lock(b_lock), .b_rdata(b_rdata), .b_ready(b_ready), .b_rst_n(b_rst_n),
        .mem_en(mem_en), .mem_we(mem_we), .mem_dsp(mem_dsp), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    dsa_shared_mem #(.PHASED(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n),
        .a_req(a_req), .a_we(a_we), .a_dsp(a_dsp), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_lock(a_lock), .a_rdata(p_a_rdata), .a_ready(p_a_ready),
        .b_req(b_req), .b_we(b_we), .b_dsp(b_dsp), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_lock(b_lock), .b_rdata(p_b_rdata), .b_ready(p_b_ready), .b_rst_n(p_b_rst_n),
        .mem_en(p_mem_en), .mem_we(p_mem_we), .mem_dsp(p_mem_dsp), .mem_addr(p_mem_addr),
        .mem_wdata(p_mem_wdata), .mem_rdata(8'h00)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Contention table: {a_req, a_lock, b_req, b_lock, exp_a_ready, exp_b_ready}.
    // Starts with the secondary core favoured and no lock held.
    localparam logic [5:0] VEC [16] = '{
        6'b1_0_1_0_0_1,  // 0  both, B favoured
        6'b1_0_1_0_1_0,  // 1  both, A's turn
        6'b1_0_1_0_0_1,  // 2
        6'b1_0_0_0_1_0,  // 3  A alone
        6'b1_0_0_0_1_0,  // 4  A alone again
        6'b0_0_0_0_0_0,  // 5  idle
        6'b1_1_1_0_0_1,  // 6  A lock but B's turn
        6'b1_1_1_0_1_0,  // 7  A locked run 1
        6'b1_1_1_0_1_0,  // 8  run 2
        6'b1_1_1_0_1_0,  // 9  run 3
        6'b1_1_1_0_1_0,  // 10 run 4, hold ends
        6'b1_1_1_0_0_1,  // 11 B after bound
        6'b1_1_1_0_1_0,  // 12 A locked run 1
        6'b0_0_1_0_0_0,  // 13 holder idle, B still waits
        6'b1_0_1_0_1_0,  // 14 holder finishes unlocked
        6'b0_0_1_0_0_1   // 15 B served
    };

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic slot0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R2 reset b_rst_n", b_rst_n, 0);
        check("R1 reset mem_en", mem_en, 0);
        check("R10 reset a_rdata", a_rdata, 0);
        check("R10 reset b_rdata", b_rdata, 0);

        // Secondary request while held in reset.
        @(negedge clk); b_req = 1; b_dsp = 1; b_addr = 24'h10;
        #1;
        check("R2 b_ready in reset", b_ready, 0);
        check("R1 no mem_en in reset", mem_en, 0);

        // Primary loads a byte into the upper code half, flat addressing.
        @(negedge clk); b_req = 0;
        a_req = 1; a_we = 1; a_dsp = 0; a_addr = 24'h8005; a_wdata = 8'h5A;
        #1;
        check("R8 a_ready single", a_ready, 1);
        check("R6 a code addr", mem_addr, 24'h008005);
        check("R1 mem_we", mem_we, 1);

        // Release and relocate: write 0x03 to the control address twice.
        @(negedge clk); a_dsp = 1; a_addr = CTRL; a_wdata = 8'h03;
        #1;
        check("R3 ctrl not in memory", mem_en, 0);
        @(negedge clk);
        @(negedge clk);
        check("R3 release", b_rst_n, 1);
        a_we = 0;
        @(negedge clk); a_req = 0;
        check("R3 ctrl readback", a_rdata, 8'h03);

        // Secondary fetches its relocated vector.
        b_req = 1; b_we = 0; b_dsp = 0; b_addr = 24'h0005;
        #1;
        check("R8 b_ready single", b_ready, 1);
        check("R5 relocated addr", mem_addr, 24'h008005);
        @(negedge clk);
        check("R10 b_rdata", b_rdata, 8'h5A);
        check("R10 a_rdata held", a_rdata, 8'h03);

        // Secondary write to the control address is dropped.
        b_we = 1; b_dsp = 1; b_addr = CTRL; b_wdata = 8'h00;
        #1;
        check("R4 ctrl b write not in memory", mem_en, 0);
        @(negedge clk); b_req = 0; b_we = 0;
        check("R4 b_rst_n kept", b_rst_n, 1);
        a_req = 1; a_we = 0; a_dsp = 1; a_addr = CTRL;
        @(negedge clk); a_req = 0;
        check("R4 ctrl unchanged", a_rdata, 8'h03);

        // Table of contention and lock cycles.
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            a_req = VEC[i][5]; a_lock = VEC[i][4]; b_req = VEC[i][3]; b_lock = VEC[i][2];
            a_we = 0; b_we = 0; a_dsp = 1; b_dsp = 1;
            a_addr = 24'h100 + 24'(i); b_addr = 24'h200 + 24'(i);
            #1;
            check($sformatf("%s a_ready vec %0d", (i < 6) ? "R7" : "R9", i), a_ready, VEC[i][1]);
            check($sformatf("%s b_ready vec %0d", (i < 6) ? "R7" : "R9", i), b_ready, VEC[i][0]);
            if (VEC[i][1]) check("R1 mem_addr A", mem_addr, 24'h100 + 24'(i));
            if (VEC[i][0]) check("R1 mem_addr B", mem_addr, 24'h200 + 24'(i));
            if (i == 0) slot0 = p_a_ready;
            if (i < 3) begin
                check("R11 slot one-hot", p_a_ready ^ p_b_ready, 1);
                check("R11 slot alternates", p_a_ready, slot0 ^ i[0]);
            end
        end
        @(negedge clk); a_req = 0; b_req = 0; a_lock = 0; b_lock = 0;

        // Primary code is never relocated.
        a_req = 1; a_dsp = 0; a_addr = 24'h0005;
        #1;
        check("R6 a code flat", mem_addr, 24'h000005);
        @(negedge clk); a_req = 0;
        b_req = 1; b_dsp = 1; b_addr = 24'h120010;
        #1;
        check("R6 b data full width", mem_addr, 24'h120010);
        @(negedge clk); b_dsp = 0; b_addr = 24'h7F9000;
        #1;
        check("R5 relocation wraps", mem_addr, 24'h001000);

        // Relocation off, release kept.
        @(negedge clk); b_req = 0;
        a_req = 1; a_we = 1; a_dsp = 1; a_addr = CTRL; a_wdata = 8'h01;
        @(negedge clk); a_req = 0; a_we = 0;
        b_req = 1; b_dsp = 0; b_addr = 24'h0005;
        #1;
        check("R5 relocation off", mem_addr, 24'h000005);

        // Put the secondary back into reset.
        @(negedge clk); b_req = 0;
        a_req = 1; a_we = 1; a_dsp = 1; a_addr = CTRL; a_wdata = 8'h00;
        @(negedge clk); a_req = 0; a_we = 0;
        check("R2 re-reset", b_rst_n, 0);
        b_req = 1;
        #1;
        check("R2 b blocked again", b_ready, 0);
        @(negedge clk); b_req = 0;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule